// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register face of a shared-memory signalling device that lets peers on a common memory region notify each other. A simple 32-bit register bus (address, read strobe, write strobe, write data, registered read data) reaches four word registers: an interrupt mask, an interrupt status word, a read-only peer identity, and a write-only doorbell. Writing the doorbell emits one outbound ring event that names a destination peer and a vector; the transport that carries it is outside the block.

Inbound notifications arrive on a side input. In legacy mode they set bit 0 of the status word, and the level interrupt output follows the masked status one cycle after the registers change. In per-vector mode they set a pending flag for the named vector instead, and each flag stays set until its acknowledge pulse. The identity register reads zero in standalone mode. In assigned-identity mode it reads all ones until an identity is delivered on a side input.

Top module: `dbell_regs`

## Requirements
- R1: After reset the mask, status and (in standalone mode) identity registers read zero, and irq, ring_valid and every pending flag are low.
- R2: Word offsets are 0x00 mask, 0x04 status, 0x08 identity, 0x0C doorbell. Read data appears in the cycle after the read strobe and is zero when no read is made. Any other offset in the 256-byte window reads zero, and writes to it change nothing.
- R3: The mask register keeps all 32 bits exactly as written.
- R4: A write to status replaces its contents. A read of status returns the current value and clears it, so a second read returns zero.
- R5: The identity register ignores writes.
- R6: With server_mode high the identity reads 0xFFFFFFFF until id_valid is seen. It then reads the delivered 16-bit identity, zero-extended.
- R7: Each doorbell write gives exactly one ring_valid pulse in the next cycle, with ring_peer = write data bits 31:16 and ring_vec = the low-order vector bits.
- R8: A doorbell read returns zero and changes neither the status word nor ring_valid.
- R9: With vec_mode high, a notify sets only pending[notify_vec] and leaves status alone. pend_ack[i] clears pending[i], and a set wins over an acknowledge in the same cycle.
- R10: With vec_mode low, a notify sets status bit 0 and leaves pending unchanged. A notify in the same cycle as a status read is not lost: the read returns the old value and bit 0 stays set.
- R11: irq is registered and equals the OR of (status AND mask) as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| server_mode | input | 1 | 1: identity assigned from outside; 0: standalone |
| id_valid | input | 1 | Delivered identity is valid this cycle |
| id_value | input | 16 | Delivered identity |
| vec_mode | input | 1 | 1: per-vector pending flags; 0: legacy status |
| notify_valid | input | 1 | Inbound notification |
| notify_vec | input | 1 | Vector of the inbound notification |
| pend_ack | input | 2 | Per-vector pending acknowledge |
| pending | output | 2 | Per-vector pending flags |
| ring_valid | output | 1 | Outbound doorbell event, one cycle |
| ring_peer | output | 16 | Destination peer of the event |
| ring_vec | output | 1 | Vector of the event |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle, that server_mode and vec_mode stay constant between resets, and that notify_vec names an existing vector. The stimulus issues every bus access as a single-strobe, one-cycle transaction. It changes the mode inputs only while reset is held, and it sends notifications only on vector 0 or 1. The identity check on the mode input tolerates a change of mode, but the stimulus never makes one outside reset.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DATA_W   = 32;
  localparam int OFS_MASK = 0;
  localparam int OFS_STAT = 4;
  localparam int OFS_POS  = 8;
  localparam int OFS_BELL = 12;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MASK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_POS  = 3'd3,
    SEL_BELL = 3'd4
  } dbell_sel_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dbell_sel_e        sel
);
  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_MASK): sel = SEL_MASK;
      ADDR_W'(OFS_STAT): sel = SEL_STAT;
      ADDR_W'(OFS_POS):  sel = SEL_POS;
      ADDR_W'(OFS_BELL): sel = SEL_BELL;
      default:           sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dbell_csr.sv
module dbell_csr
  import dbell_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dbell_sel_e        sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              server_mode,
  input  logic              id_valid,
  input  logic [ID_W-1:0]   id_value,
  input  logic              legacy_hit,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] mask_q, status_q, stat_nxt, pos_val, rd_mux;
  logic [ID_W-1:0]   id_q;
  logic              id_have;

  always_comb begin
    stat_nxt = status_q;
    if (wr && sel == SEL_STAT)      stat_nxt = wdata;
    else if (rd && sel == SEL_STAT) stat_nxt = '0;
    if (legacy_hit)                 stat_nxt[0] = 1'b1;
  end

  always_comb begin
    if (!server_mode)  pos_val = '0;
    else if (id_have)  pos_val = {{(DATA_W-ID_W){1'b0}}, id_q};
    else               pos_val = '1;
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = status_q;
      SEL_POS:  rd_mux = pos_val;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      status_q <= '0;
      id_q     <= '0;
      id_have  <= 1'b0;
      rdata    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr && sel == SEL_MASK) mask_q <= wdata;
      status_q <= stat_nxt;
      if (id_valid) begin
        id_q    <= id_value;
        id_have <= 1'b1;
      end
      rdata <= rd ? rd_mux : '0;
      irq   <= |(status_q & mask_q);
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_MASK) |=> $stable(mask_q)); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_MASK) |=> mask_q == $past(wdata)); // R3
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_STAT && !legacy_hit) |=> status_q == '0); // R4
  AST_STAT_RETURN: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_STAT) |=> rdata == $past(status_q)); // R4
  AST_POS_FIXED: assert property (@(posedge clk) disable iff (rst)
    !id_valid |=> ($stable(pos_val) || !$stable(server_mode))); // R5
  AST_LEGACY_BIT: assert property (@(posedge clk) disable iff (rst)
    legacy_hit |=> status_q[0]); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((status_q & mask_q) != '0)); // R11
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0); // R2
endmodule

// File: rtl/dbell_ring.sv
module dbell_ring #(
  parameter int ID_W  = 16,
  parameter int VEC_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [ID_W-1:0]  peer_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic             valid,
  output logic [ID_W-1:0]  peer,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      peer  <= '0;
      vec   <= '0;
    end else begin
      valid <= fire;
      if (fire) begin
        peer <= peer_in;
        vec  <= vec_in;
      end
    end
  end

  AST_RING_EVENT: assert property (@(posedge clk) disable iff (rst)
    fire |=> valid && peer == $past(peer_in) && vec == $past(vec_in)); // R7
  AST_RING_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !valid); // R8
endmodule

// File: rtl/dbell_vec.sv
module dbell_vec #(
  parameter int NVEC  = 2,
  parameter int VEC_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [VEC_W-1:0] vec,
  input  logic [NVEC-1:0]  ack,
  output logic [NVEC-1:0]  pending
);
  for (genvar i = 0; i < NVEC; i++) begin : g_flag
    logic set_i;
    assign set_i = hit && (int'(vec) == i);
    always_ff @(posedge clk) begin
      if (rst)        pending[i] <= 1'b0;
      else if (set_i) pending[i] <= 1'b1;
      else if (ack[i]) pending[i] <= 1'b0;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (hit && int'(vec) < NVEC) |=> $countones(pending & ~$past(pending)) <= 1); // R9
  AST_PEND_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!hit && ack == '0) |=> $stable(pending)); // R9
  AST_PEND_NOSET: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (pending & ~$past(pending)) == '0); // R10
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 16,
  parameter int NVEC   = 2,
  localparam int VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              server_mode,
  input  logic              id_valid,
  input  logic [ID_W-1:0]   id_value,
  input  logic              vec_mode,
  input  logic              notify_valid,
  input  logic [VEC_W-1:0]  notify_vec,
  input  logic [NVEC-1:0]   pend_ack,
  output logic [NVEC-1:0]   pending,
  output logic              ring_valid,
  output logic [ID_W-1:0]   ring_peer,
  output logic [VEC_W-1:0]  ring_vec,
  output logic              irq
);
  dbell_sel_e sel;
  logic       legacy_hit, vector_hit, bell_fire;

  assign legacy_hit = notify_valid && !vec_mode;
  assign vector_hit = notify_valid && vec_mode;
  assign bell_fire  = bus_wr && (sel == SEL_BELL);

  dbell_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  dbell_csr #(.ID_W(ID_W)) u_csr (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .wdata       (bus_wdata),
    .server_mode (server_mode),
    .id_valid    (id_valid),
    .id_value    (id_value),
    .legacy_hit  (legacy_hit),
    .rdata       (bus_rdata),
    .irq         (irq)
  );

  dbell_ring #(.ID_W(ID_W), .VEC_W(VEC_W)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .fire    (bell_fire),
    .peer_in (bus_wdata[DATA_W-1 -: ID_W]),
    .vec_in  (bus_wdata[VEC_W-1:0]),
    .valid   (ring_valid),
    .peer    (ring_peer),
    .vec     (ring_vec)
  );

  dbell_vec #(.NVEC(NVEC), .VEC_W(VEC_W)) u_vec (
    .clk     (clk),
    .rst     (rst),
    .hit     (vector_hit),
    .vec     (notify_vec),
    .ack     (pend_ack),
    .pending (pending)
  );

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R2
  AST_PEND_LEGACY: assert property (@(posedge clk) disable iff (rst)
    (legacy_hit && pend_ack == '0) |=> $stable(pending)); // R10
endmodule

// File: tb/tb_dbell_regs.sv
`timescale 1ns/1ps
module tb_dbell_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        server_mode = 1'b0, id_valid = 1'b0;
  logic [15:0] id_value = '0;
  logic        vec_mode = 1'b0, notify_valid = 1'b0;
  logic        notify_vec = 1'b0;
  logic [1:0]  pend_ack = '0;
  logic [1:0]  pending;
  logic        ring_valid;
  logic [15:0] ring_peer;
  logic        ring_vec;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dbell_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .server_mode(server_mode),
    .id_valid(id_valid), .id_value(id_value), .vec_mode(vec_mode),
    .notify_valid(notify_valid), .notify_vec(notify_vec), .pend_ack(pend_ack),
    .pending(pending), .ring_valid(ring_valid), .ring_peer(ring_peer),
    .ring_vec(ring_vec), .irq(irq)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 8'h00, 32'h0000_0000, 8'd1},  // R1 mask
    '{1'b1, 8'h04, 32'h0000_0000, 8'd1},  // R1 status
    '{1'b1, 8'h08, 32'h0000_0000, 8'd1},  // R1 identity, standalone
    '{1'b0, 8'h00, 32'hFFFF_FFFF, 8'd3},
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'd3},  // R3
    '{1'b0, 8'h00, 32'h0000_A5A5, 8'd3},
    '{1'b1, 8'h00, 32'h0000_A5A5, 8'd3},  // R3
    '{1'b0, 8'h04, 32'h0000_0001, 8'd4},
    '{1'b1, 8'h04, 32'h0000_0001, 8'd4},  // R4 first read
    '{1'b1, 8'h04, 32'h0000_0000, 8'd4},  // R4 cleared
    '{1'b0, 8'h08, 32'h0000_0001, 8'd5},
    '{1'b1, 8'h08, 32'h0000_0000, 8'd5},  // R5
    '{1'b1, 8'h0C, 32'h0000_0000, 8'd8},  // R8
    '{1'b0, 8'h40, 32'h0000_1234, 8'd2},
    '{1'b1, 8'h40, 32'h0000_0000, 8'd2},  // R2 unmapped
    '{1'b1, 8'h00, 32'h0000_A5A5, 8'd2},  // R2 untouched
    '{1'b0, 8'h04, 32'h0000_00F0, 8'd4},
    '{1'b1, 8'h04, 32'h0000_00F0, 8'd4}   // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 ring_valid", {31'b0, ring_valid}, 32'h0);
    check("R1 pending", {30'b0, pending}, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i].is_rd) begin
        bus_read(STEPS[i].addr, v);
        check($sformatf("R%0d step %0d", STEPS[i].req, i), v, STEPS[i].data);
      end else begin
        bus_write(STEPS[i].addr, STEPS[i].data);
      end
    end

    // R2: read data is zero when no read strobe
    @(negedge clk);
    check("R2 idle rdata", bus_rdata, 32'h0);

    // R7: doorbell event
    do_reset();
    bus_write(8'h0C, 32'h0003_0001);
    check("R7 ring_valid", {31'b0, ring_valid}, 32'h1);
    check("R7 ring_peer", {16'b0, ring_peer}, 32'h3);
    check("R7 ring_vec", {31'b0, ring_vec}, 32'h1);
    @(negedge clk);
    check("R7 single pulse", {31'b0, ring_valid}, 32'h0);

    // R8: doorbell read, no side effect
    bus_write(8'h04, 32'h0000_0055);
    bus_read(8'h0C, v);
    check("R8 doorbell reads zero", v, 32'h0);
    check("R8 no ring", {31'b0, ring_valid}, 32'h0);
    bus_read(8'h04, v);
    check("R8 status intact", v, 32'h55);

    // R11: irq lag
    do_reset();
    bus_write(8'h00, 32'h0000_0001);
    bus_write(8'h04, 32'h0000_0001);
    check("R11 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R11 irq raised", {31'b0, irq}, 32'h1);
    bus_read(8'h04, v);
    check("R11 irq held one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R11 irq dropped", {31'b0, irq}, 32'h0);

    // R10: legacy notify
    do_reset();
    notify_valid = 1'b1; notify_vec = 1'b1;
    @(negedge clk);
    notify_valid = 1'b0;
    check("R10 pending untouched", {30'b0, pending}, 32'h0);
    bus_read(8'h04, v);
    check("R10 status bit0", v, 32'h1);
    bus_write(8'h04, 32'h0000_0006);
    bus_addr = 8'h04; bus_rd = 1'b1; notify_valid = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; notify_valid = 1'b0;
    check("R10 read old value", bus_rdata, 32'h6);
    bus_read(8'h04, v);
    check("R10 notify kept", v, 32'h1);

    // R9: per-vector mode
    rst = 1'b1; vec_mode = 1'b1;
    do_reset();
    notify_valid = 1'b1; notify_vec = 1'b1;
    @(negedge clk);
    notify_valid = 1'b0;
    check("R9 only vector 1", {30'b0, pending}, 32'h2);
    bus_read(8'h04, v);
    check("R9 status untouched", v, 32'h0);
    pend_ack = 2'b10;
    @(negedge clk);
    pend_ack = 2'b00;
    check("R9 ack clears", {30'b0, pending}, 32'h0);
    notify_valid = 1'b1; notify_vec = 1'b0; pend_ack = 2'b01;
    @(negedge clk);
    notify_valid = 1'b0; pend_ack = 2'b00;
    check("R9 set wins over ack", {30'b0, pending}, 32'h1);

    // R6: assigned identity
    rst = 1'b1; vec_mode = 1'b0; server_mode = 1'b1;
    do_reset();
    bus_read(8'h08, v);
    check("R6 unassigned", v, 32'hFFFF_FFFF);
    id_value = 16'h0005; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    bus_read(8'h08, v);
    check("R6 assigned", v, 32'h5);
    bus_write(8'h08, 32'h0000_0009);
    bus_read(8'h08, v);
    check("R5 write ignored in server mode", v, 32'h5);

    finish_run();
  end
endmodule